// File: doc/BRIEF.md
# Replaying Outcome-Pattern Branch Direction Predictor

This block predicts the direction of one branch whose taken/not-taken history repeats with a fixed period of `N` outcomes. It stores one whole period of outcomes in an `N`-bit register and offers the oldest pending outcome, the most significant bit, as its prediction on every cycle. Software or a surrounding unit supplies the expected outcome pattern on `pattern_i`. The block captures that pattern while reset is held and on every `load_i` pulse.

Each `resolve_i` pulse delivers the real outcome of the branch. The block raises `mispredict_o` in that same cycle if the outcome differs from the current prediction. At the next edge it advances the stored pattern by one position. After a wrong guess it also complements every stored bit. A branch that follows the stored pattern is therefore never mispredicted. A branch that follows the exact complement of the pattern is mispredicted once and is then tracked without error.

Top module: `patpred_top`

## Requirements
- R1: While `rst_n` is low, each rising clock edge copies `pattern_i` into the register, so after reset `predict_o` equals `pattern_i[N-1]`.
- R2: With `rst_n` high and `load_i` high, a rising edge copies `pattern_i` into the register.
- R3: `predict_o` always equals bit N-1 of the register. A value of 1 means taken and 0 means not taken.
- R4: On a resolve (`resolve_i`=1, `load_i`=0) whose outcome matches the prediction, the register rotates left by one position, and the old bit N-1 becomes bit 0.
- R5: On a resolve whose outcome differs from the prediction, the register takes the bitwise complement of its left-rotated value.
- R6: `mispredict_o` is combinational. It is 1 exactly when `rst_n`=1, `resolve_i`=1, `load_i`=0 and `outcome_i` differs from `predict_o`.
- R7: When neither `load_i` nor `resolve_i` is high (and reset is released), the register keeps its value.
- R8: When `load_i` and `resolve_i` are both high, the load wins, the outcome is ignored, and `mispredict_o` stays 0.
- R9: Outcomes that follow the loaded pattern, MSB first and repeating, never mispredict. Outcomes that follow its complement mispredict only on the first resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset that also loads the pattern |
| load_i | input | 1 | Reload the register from `pattern_i` |
| pattern_i | input | N | Expected outcome pattern; bit N-1 is predicted first |
| resolve_i | input | 1 | One real branch outcome is presented this cycle |
| outcome_i | input | 1 | Real outcome, 1 = taken |
| predict_o | output | 1 | Current direction prediction, 1 = taken |
| mispredict_o | output | 1 | The outcome presented this cycle differs from the prediction |

## Verification
The bench feeds the stored pattern back as outcomes over several periods. A zero miss count there separates a correct left rotation from a wrong shift direction or a missing wrap-around bit. It then feeds the complementary pattern, which checks that a miss complements every bit and that exactly one miss occurs. Irregular outcomes from a bench LFSR mix hits and misses. Idle gaps show that the state holds without a resolve. Cycles that carry both a load and a resolve check which of the two takes priority.

// File: rtl/patpred_pkg.sv
package patpred_pkg;

  // Left rotation by one place: the MSB wraps around to bit 0.
  function automatic logic [63:0] rot_left(input logic [63:0] v, input int unsigned w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) r[i] = (i == 0) ? v[w-1] : v[i-1];
    end
    return r;
  endfunction

  // Next state after a resolve: rotate, then complement every bit if the guess was wrong.
  function automatic logic [63:0] advance(input logic [63:0] v, input int unsigned w,
                                          input logic wrong);
    logic [63:0] r;
    r = rot_left(v, w);
    for (int i = 0; i < 64; i++) begin
      if (i < w && wrong) r[i] = ~r[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/patpred_judge.sv
module patpred_judge (
  input  logic rst_n,
  input  logic load_i,
  input  logic resolve_i,
  input  logic outcome_i,
  input  logic guess_i,
  output logic resolve_evt_o,
  output logic miss_evt_o
);
  // A resolve counts only outside reset and when no load overrides it.
  assign resolve_evt_o = rst_n & resolve_i & ~load_i;
  assign miss_evt_o    = resolve_evt_o & (outcome_i ^ guess_i);
endmodule

// File: rtl/patpred_store.sv
module patpred_store #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] pattern_i,
  input  logic         step_i,
  input  logic         wrong_i,
  output logic [N-1:0] state_o
);
  import patpred_pkg::*;

  logic [N-1:0] state_q;
  logic [N-1:0] next_step;
  logic [63:0]  wide_next;

  assign wide_next = advance(64'(state_q), N, wrong_i);
  assign next_step = wide_next[N-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || load_i) state_q <= pattern_i;
    else if (step_i)      state_q <= next_step;
  end

  assign state_o = state_q;
endmodule

// File: rtl/patpred_top.sv
module patpred_top #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] pattern_i,
  input  logic         resolve_i,
  input  logic         outcome_i,
  output logic         predict_o,
  output logic         mispredict_o
);
  localparam int unsigned MSB = N - 1;

  logic [N-1:0] state_q;
  logic         resolve_evt;
  logic         miss_evt;

  patpred_judge u_judge (
    .rst_n        (rst_n),
    .load_i       (load_i),
    .resolve_i    (resolve_i),
    .outcome_i    (outcome_i),
    .guess_i      (state_q[MSB]),
    .resolve_evt_o(resolve_evt),
    .miss_evt_o   (miss_evt)
  );

  patpred_store #(.N(N)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .pattern_i(pattern_i),
    .step_i   (resolve_evt),
    .wrong_i  (miss_evt),
    .state_o  (state_q)
  );

  assign predict_o    = state_q[MSB];
  assign mispredict_o = miss_evt;
endmodule

// File: rtl/patpred_chk.sv
module patpred_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic [N-1:0] pattern_i,
  input logic         resolve_i,
  input logic         outcome_i,
  input logic         predict_o,
  input logic         mispredict_o,
  input logic [N-1:0] state_q
);
  AST_RESET_LOADS: assert property (@(posedge clk) !rst_n |=> state_q == $past(pattern_i)); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> state_q == $past(pattern_i)); // R2
  AST_HIT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && !load_i && outcome_i == predict_o) |=>
      state_q == {$past(state_q[N-2:0]), $past(state_q[N-1])}); // R4
  AST_MISS_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && !load_i && outcome_i != predict_o) |=>
      state_q == ~{$past(state_q[N-2:0]), $past(state_q[N-1])}); // R5
  AST_FLAG_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_o |-> resolve_i && outcome_i != predict_o); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!resolve_i && !load_i) |=> $stable(state_q)); // R7
  AST_LOAD_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !mispredict_o); // R8
endmodule

bind patpred_top patpred_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .pattern_i(pattern_i),
  .resolve_i(resolve_i), .outcome_i(outcome_i), .predict_o(predict_o),
  .mispredict_o(mispredict_o), .state_q(state_q)
);

// File: tb/sim_patpred_top.sv
`timescale 1ns/1ps
module sim_patpred_top;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [N-1:0] pattern_i = '0;
  logic resolve_i = 1'b0;
  logic outcome_i = 1'b0;
  logic predict_o, mispredict_o;

  always #2 clk = ~clk;

  patpred_top #(.N(N)) u0 (.*);

  typedef struct {
    logic  pred;
    logic  miss;
    string tag;
  } item_t;
  item_t q[$];

  int tests = 0;
  int fails = 0;
  int miss_seen = 0;
  logic [N-1:0] model = '0;
  bit done = 0;

  // Driver: apply one cycle of inputs, push the expectation, advance the reference.
  task automatic step(input logic rst, input logic ld, input logic [N-1:0] pat,
                      input logic res, input logic out, input bit chk, input string tag);
    item_t it;
    logic exp_miss;
    @(negedge clk);
    rst_n = ~rst; load_i = ld; pattern_i = pat; resolve_i = res; outcome_i = out;
    exp_miss = !rst && !ld && res && (out != model[N-1]);
    if (chk) begin
      it.pred = model[N-1]; it.miss = exp_miss; it.tag = tag;
      q.push_back(it);
    end
    if (exp_miss) miss_seen++;
    if (rst || ld) model = pat;
    else if (res) model = (((model << 1) | (model >> (N-1))) & MASK) ^ (exp_miss ? MASK : '0);
  endtask

  // Monitor: compare outputs shortly after each negative edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        tests++;
        if (predict_o !== it.pred || mispredict_o !== it.miss) begin
          fails++;
          $display("FAIL %s: predict=%b mispredict=%b expected predict=%b mispredict=%b",
                   it.tag, predict_o, mispredict_o, it.pred, it.miss);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pa;
    logic [7:0] lfsr;
    int m0;
    pa = 8'b1011_0010;
    // R1: reset loads the pattern
    step(1, 0, pa, 0, 0, 0, "R1");
    step(1, 0, pa, 0, 0, 0, "R1");
    step(0, 0, pa, 0, 0, 1, "R1 reset state");
    // R9 / R4: outcomes follow the stored pattern for three periods
    m0 = miss_seen;
    for (int k = 0; k < 3*N; k++) step(0, 0, pa, 1, pa[N-1-(k%N)], 1, "R4 R9 matched");
    step(0, 0, pa, 0, 0, 1, "R3 after matched run");
    tests++;
    if (miss_seen != m0) begin
      fails++; $display("FAIL R9: misses=%0d expected=0", miss_seen - m0);
    end
    // R7: idle cycles hold the state
    for (int k = 0; k < 5; k++) step(0, 0, 8'h00, 0, 1, 1, "R7 idle hold");
    // R2 / R9 / R5: reload, then feed the complement pattern
    step(0, 1, pa, 0, 0, 1, "R2 load");
    m0 = miss_seen;
    for (int k = 0; k < 2*N; k++) step(0, 0, 8'h00, 1, ~pa[N-1-(k%N)], 1, "R5 R9 complement");
    step(0, 0, pa, 0, 0, 1, "R5 after complement run");
    tests++;
    if (miss_seen - m0 != 1) begin
      fails++; $display("FAIL R9: misses=%0d expected=1", miss_seen - m0);
    end
    // R8: load and resolve together, with a mismatching outcome
    step(0, 1, 8'b0110_1001, 1, 1, 1, "R8 load wins");
    step(0, 1, 8'b1100_0011, 1, 0, 1, "R8 load wins");
    step(0, 0, 8'h00, 0, 0, 1, "R8 loaded value");
    // R6 / R4 / R5: irregular outcomes
    lfsr = 8'hA5;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(0, 0, 8'h00, lfsr[2] | lfsr[6], lfsr[0], 1, "R6 irregular");
    end
    // R1: reset again mid-run with a new pattern
    step(1, 0, 8'b0101_0111, 1, 1, 1, "R1 reset mid-run");
    step(0, 0, 8'h00, 0, 0, 1, "R1 after reset");
    for (int k = 0; k < N; k++) step(0, 0, 8'h00, 1, 8'b0101_0111 >> (N-1-k), 1, "R4 post reset");
    step(0, 0, 8'h00, 0, 0, 1, "R3 final");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule